// File: doc/BRIEF.md
# PWM Prescaled and Scaled Clock Generator

This block turns one bus clock into the timing enables that the channels of a six-channel pulse-width modulator count on. A shared free-running prescale counter yields two prescaled enables, A and B. Each divides the bus clock by a power of two, from 1 to 128, set by its own 3-bit code. Behind each prescaled enable sits an even-ratio scaler. The scaler counts prescaled pulses and gives one scaled pulse for every 2·N of them, so SA comes from A and SB comes from B. Each channel then takes either the prescaled or the scaled enable of its pair through one select bit.

Every output is a single-cycle enable pulse in the bus clock domain. The prescale counter stops in two cases: when freeze gating is enabled and the freeze input is high, and when no channel is enabled. While it is stopped, all derived enables hold their phase and stay low. When a scaler's reload value changes, that scaler restarts its count at once, so the new ratio applies from the next edge.

Top module: `pwm_clkgen`

## Requirements
- R1: After reset, with the prescaler running and A code k (0 to 7), `tick_a` pulses exactly once in every 2^k bus cycles. Code 0 gives a pulse on every running cycle.
- R2: `tick_b` follows its own code `pre_b_code` in the same way as R1, independently of the A code.
- R3: With an 8-bit reload value N, where N = 0 stands for 256, `tick_sa` pulses once for every 2·N pulses of `tick_a`. `tick_sb` does the same from `tick_b` using `scl_b_val`.
- R4: A scaled pulse only occurs in a cycle where its source prescaled enable also pulses.
- R5: `chan_tick[i]` equals the scaled enable of its pair when `chan_sel[i]` = 1 and the prescaled enable when it is 0. Channels 0, 1, 4 and 5 use A/SA. Channels 2 and 3 use B/SB.
- R6: While `frz_gate_en` = 1 and `freeze` = 1, no enable output pulses.
- R7: While `chan_en` = 0, no enable output pulses.
- R8: A change of a scaler's reload value restarts that scaler. The first scaled pulse comes with the 2·N-th source pulse after the edge that sees the new value.
- R9: `freeze` has no effect while `frz_gate_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| freeze | input | 1 | Freeze request from the debug environment |
| frz_gate_en | input | 1 | Allows `freeze` to stop the prescaler |
| chan_en | input | 6 | Channel enables; all zero stops the prescaler |
| pre_a_code | input | 3 | Clock A divide code k, ratio 2^k |
| pre_b_code | input | 3 | Clock B divide code k, ratio 2^k |
| scl_a_val | input | 8 | Scaler A reload N, divide 2·N, 0 means 256 |
| scl_b_val | input | 8 | Scaler B reload N, divide 2·N, 0 means 256 |
| chan_sel | input | 6 | Per channel: 1 selects scaled, 0 selects prescaled |
| tick_a | output | 1 | Prescaled enable A |
| tick_b | output | 1 | Prescaled enable B |
| tick_sa | output | 1 | Scaled enable SA |
| tick_sb | output | 1 | Scaled enable SB |
| chan_tick | output | 6 | Per-channel clock enable |

## Verification
The bench builds the block with its default parameters: a 3-bit prescale code, an 8-bit reload value and six channels. These defaults make every prescale ratio up to 128 and the full 512 scaler ratio reachable within short counting windows. The scaler boundary values 1, 2, 255 and 0 run at prescale code 0, which keeps their longest period at 512 cycles. Random codes and reload values are constrained so that every window is a whole number of periods, which makes the pulse counts exact whatever the phase.

// File: rtl/pwm_clk_pkg.sv
package pwm_clk_pkg;
    localparam int unsigned CODE_W_DEF = 3;
    localparam int unsigned VAL_W_DEF  = 8;
    localparam int unsigned NCH_DEF    = 6;
    // bit set = channel on the B/SB pair
    localparam logic [NCH_DEF-1:0] PAIR_B_DEF = 6'b001100;
endpackage

// File: rtl/pwm_pow2_prescaler.sv
module pwm_pow2_prescaler #(
    parameter int unsigned CODE_W = pwm_clk_pkg::CODE_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code_a,
    input  logic [CODE_W-1:0] code_b,
    output logic              tick_a,
    output logic              tick_b
);
    localparam int unsigned CNT_W = (1 << CODE_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [CNT_W:0] mask_a_d, mask_b_d;

    always_comb begin
        st_d = st_q;
        mask_a_d = ({{CNT_W{1'b0}}, 1'b1} << code_a) - 1'b1;
        mask_b_d = ({{CNT_W{1'b0}}, 1'b1} << code_b) - 1'b1;
        if (run) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        tick_a = run && ((st_q.cnt & mask_a_d[CNT_W-1:0]) == mask_a_d[CNT_W-1:0]);
        tick_b = run && ((st_q.cnt & mask_b_d[CNT_W-1:0]) == mask_b_d[CNT_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6/R7: a stopped prescaler keeps its phase
    a_r6_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(st_q.cnt));
    // R1: a running counter advances by one
    a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
endmodule

// File: rtl/pwm_even_scaler.sv
module pwm_even_scaler #(
    parameter int unsigned VAL_W = pwm_clk_pkg::VAL_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic [VAL_W-1:0] reload,
    output logic             tick_out
);
    localparam int unsigned CNT_W = VAL_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [VAL_W-1:0] last;
    } scl_state_t;

    scl_state_t st_d, st_q;
    logic [CNT_W-1:0] n_eff_d, lim_d;
    logic             reload_hit_d;

    always_comb begin
        st_d = st_q;
        n_eff_d = (reload == '0) ? CNT_W'(1 << VAL_W) : CNT_W'(reload);
        lim_d = {n_eff_d[CNT_W-2:0], 1'b0} - 1'b1;
        reload_hit_d = (reload != st_q.last);
        st_d.last = reload;
        if (reload_hit_d) begin
            st_d.cnt = '0;
        end else if (tick_in) begin
            st_d.cnt = (st_q.cnt == lim_d) ? '0 : st_q.cnt + 1'b1;
        end
        tick_out = tick_in && !reload_hit_d && (st_q.cnt == lim_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a new reload value restarts the count
    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (reload != st_q.last) |=> (st_q.cnt == '0));
    // R3: no source pulse, no count movement
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && (reload == st_q.last)) |=> $stable(st_q.cnt));
endmodule

// File: rtl/pwm_chan_select.sv
module pwm_chan_select #(
    parameter int unsigned         NCH    = pwm_clk_pkg::NCH_DEF,
    parameter logic [NCH-1:0]      PAIR_B = pwm_clk_pkg::PAIR_B_DEF
) (
    input  logic           tick_a,
    input  logic           tick_b,
    input  logic           tick_sa,
    input  logic           tick_sb,
    input  logic [NCH-1:0] sel,
    output logic [NCH-1:0] chan_tick
);
    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        if (PAIR_B[gi]) begin : g_b
            assign chan_tick[gi] = sel[gi] ? tick_sb : tick_b;
        end else begin : g_a
            assign chan_tick[gi] = sel[gi] ? tick_sa : tick_a;
        end
    end
endmodule

// File: rtl/pwm_clkgen.sv
module pwm_clkgen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       freeze,
    input  logic       frz_gate_en,
    input  logic [5:0] chan_en,
    input  logic [2:0] pre_a_code,
    input  logic [2:0] pre_b_code,
    input  logic [7:0] scl_a_val,
    input  logic [7:0] scl_b_val,
    input  logic [5:0] chan_sel,
    output logic       tick_a,
    output logic       tick_b,
    output logic       tick_sa,
    output logic       tick_sb,
    output logic [5:0] chan_tick
);
    import pwm_clk_pkg::*;

    logic run_d;

    always_comb begin
        run_d = !(frz_gate_en && freeze) && (chan_en != '0);
    end

    pwm_pow2_prescaler #(.CODE_W(CODE_W_DEF)) i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_d),
        .code_a (pre_a_code),
        .code_b (pre_b_code),
        .tick_a (tick_a),
        .tick_b (tick_b)
    );

    pwm_even_scaler #(.VAL_W(VAL_W_DEF)) i_scl_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (tick_a),
        .reload   (scl_a_val),
        .tick_out (tick_sa)
    );

    pwm_even_scaler #(.VAL_W(VAL_W_DEF)) i_scl_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (tick_b),
        .reload   (scl_b_val),
        .tick_out (tick_sb)
    );

    pwm_chan_select #(.NCH(NCH_DEF), .PAIR_B(PAIR_B_DEF)) i_sel (
        .tick_a    (tick_a),
        .tick_b    (tick_b),
        .tick_sa   (tick_sa),
        .tick_sb   (tick_sb),
        .sel       (chan_sel),
        .chan_tick (chan_tick)
    );

    a_r6_frozen_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_gate_en && freeze) |-> (chan_tick == '0 && !tick_sa && !tick_sb));
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en == '0) |-> (chan_tick == '0 && !tick_a && !tick_b));
    a_r4_sa_in_a: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sa |-> tick_a);
    a_r4_sb_in_b: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sb |-> tick_b);
    a_r5_ch2_pair: assert property (@(posedge clk) disable iff (!rst_n)
        chan_tick[2] |-> (tick_b || tick_sb));
endmodule

// File: tb/test_pwm_clkgen.sv
module test_pwm_clkgen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       freeze = 1'b0;
    logic       frz_gate_en = 1'b0;
    logic [5:0] chan_en = 6'h3f;
    logic [2:0] pre_a_code = 3'd0;
    logic [2:0] pre_b_code = 3'd0;
    logic [7:0] scl_a_val = 8'd1;
    logic [7:0] scl_b_val = 8'd1;
    logic [5:0] chan_sel = 6'h00;
    logic       tick_a, tick_b, tick_sa, tick_sb;
    logic [5:0] chan_tick;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int c_a, c_b, c_sa, c_sb;
    int c_ch [6];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_clkgen i_pwm_clkgen (
        .clk(clk), .rst_n(rst_n), .freeze(freeze), .frz_gate_en(frz_gate_en),
        .chan_en(chan_en), .pre_a_code(pre_a_code), .pre_b_code(pre_b_code),
        .scl_a_val(scl_a_val), .scl_b_val(scl_b_val), .chan_sel(chan_sel),
        .tick_a(tick_a), .tick_b(tick_b), .tick_sa(tick_sa), .tick_sb(tick_sb),
        .chan_tick(chan_tick)
    );

    function automatic int n_eff(input logic [7:0] v);
        return (v == 0) ? 256 : int'(v);
    endfunction

    function automatic int pre_period(input logic [2:0] k);
        return 1 << k;
    endfunction

    function automatic bit on_b(input int ch);
        return (ch == 2) || (ch == 3);
    endfunction

    task automatic check(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_window(input int cycles);
        c_a = 0; c_b = 0; c_sa = 0; c_sb = 0;
        for (int i = 0; i < 6; i++) c_ch[i] = 0;
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            c_a += int'(tick_a);
            c_b += int'(tick_b);
            c_sa += int'(tick_sa);
            c_sb += int'(tick_sb);
            for (int i = 0; i < 6; i++) c_ch[i] += int'(chan_tick[i]);
        end
    endtask

    // check pair A (R1, R3, R5) over a whole number of SA periods
    task automatic check_pair_a(input string tag);
        int pa, psa, w;
        pa = pre_period(pre_a_code);
        psa = pa * 2 * n_eff(scl_a_val);
        w = 2 * psa;
        repeat (3) @(negedge clk);
        count_window(w);
        check(c_a, w / pa, {"R1 ", tag});
        check(c_sa, w / psa, {"R3 ", tag});
        for (int i = 0; i < 6; i++)
            if (!on_b(i)) check(c_ch[i], chan_sel[i] ? c_sa : c_a, {"R5 ", tag});
    endtask

    task automatic check_pair_b(input string tag);
        int pb, psb, w;
        pb = pre_period(pre_b_code);
        psb = pb * 2 * n_eff(scl_b_val);
        w = 2 * psb;
        repeat (3) @(negedge clk);
        count_window(w);
        check(c_b, w / pb, {"R2 ", tag});
        check(c_sb, w / psb, {"R3 ", tag});
        for (int i = 0; i < 6; i++)
            if (on_b(i)) check(c_ch[i], chan_sel[i] ? c_sb : c_b, {"R5 ", tag});
    endtask

    initial begin
        for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int first;
        void'($urandom(32'd1234));
        @(negedge clk);
        // R1: reset state, no pulses from A scaled path while held
        check(int'(tick_sa) + int'(tick_sb), 0, "R1 reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: every prescale code, A and B on opposite codes
        for (int k = 0; k < 8; k++) begin
            pre_a_code = 3'(k);
            pre_b_code = 3'(7 - k);
            scl_a_val = 8'd1;
            scl_b_val = 8'd1;
            chan_sel = 6'b010101;
            check_pair_a("prescale sweep");
            check_pair_b("prescale sweep");
        end

        // R3: scaler boundary values at code 0
        pre_a_code = 3'd0;
        pre_b_code = 3'd0;
        chan_sel = 6'b111111;
        scl_a_val = 8'd1;   scl_b_val = 8'd2;   check_pair_a("N=1"); check_pair_b("N=2");
        scl_a_val = 8'd255; scl_b_val = 8'd0;   check_pair_a("N=255"); check_pair_b("N=0");
        scl_a_val = 8'd0;   scl_b_val = 8'd255; check_pair_a("N=0"); check_pair_b("N=255");

        // R8: reload restart, first pulse on sample 2N
        pre_a_code = 3'd0;
        scl_a_val = 8'd3;
        repeat (7) @(negedge clk);
        scl_a_val = 8'd5;
        first = 0;
        for (int s = 1; s <= 12; s++) begin
            @(negedge clk);
            if (tick_sa && first == 0) first = s;
        end
        check(first, 10, "R8 restart");

        // R6: frozen with gating enabled
        scl_a_val = 8'd1; scl_b_val = 8'd1;
        frz_gate_en = 1'b1; freeze = 1'b1;
        @(negedge clk);
        count_window(300);
        check(c_a + c_b + c_sa + c_sb, 0, "R6 frozen prescaled/scaled");
        check(c_ch[0] + c_ch[1] + c_ch[2] + c_ch[3] + c_ch[4] + c_ch[5], 0, "R6 frozen channels");

        // R9: freeze ignored without the gate bit
        frz_gate_en = 1'b0;
        chan_sel = 6'b000000;
        check_pair_a("R9 ungated freeze");
        freeze = 1'b0;

        // R7: all channels disabled
        chan_en = 6'h00;
        @(negedge clk);
        count_window(300);
        check(c_a + c_b + c_sa + c_sb, 0, "R7 idle prescaled/scaled");
        check(c_ch[0] + c_ch[3], 0, "R7 idle channels");
        chan_en = 6'h01;

        // random mix; R4 via per-pair counts
        for (int it = 0; it < 12; it++) begin
            pre_a_code = 3'($urandom_range(0, 3));
            pre_b_code = 3'($urandom_range(0, 3));
            scl_a_val = 8'($urandom_range(1, 12));
            scl_b_val = 8'($urandom_range(1, 12));
            chan_sel = 6'($urandom_range(0, 63));
            chan_en = 6'($urandom_range(1, 63));
            check_pair_a("random");
            check_pair_b("random");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule